// File: doc/BRIEF.md
# Detector Fast-Control Sequencer

This block is the fast-control state machine for a pixel readout chip. It moves the chip between its operating modes by sending short command telegrams on a serial line that is qualified by the control clock. A request port lets software ask for one of three single modes: burst, readout or test pattern. Software can also ask for the usual combined action, which is a burst that flows straight into a readout with no host step between the two.

An auto-repeat timer can launch the combined action on its own at a fixed period of 10,000,000 control-clock cycles. At a 100 MHz control clock this gives a 10 Hz rate. The period is a parameter, so a simulation can use a shorter one. During each mode a position counter gives the location inside the measurement cycle, at one control-clock step (10 ns) per count. Three auxiliary outputs, named clear, clear-gate and inner-substrate, are each driven high over a programmable counter window during a burst. The current mode is exported for other logic.

Top module: `fc_sequencer`

## Requirements
- R1: A request with kind 0, 1 or 2 enters burst, readout or test mode at the next clock edge. Burst lasts BURST_CYC cycles, readout lasts READ_CYC cycles and test lasts TEST_CYC cycles. After that the block returns to idle.
- R2: A request with kind 3 runs a burst. The clock edge that ends the burst enters readout directly, with no idle cycle between them. Idle follows the readout.
- R3: When a mode is entered, tx_data carries a high start bit in the first cycle. The 4-bit command code of the mode follows, MSB first, one bit per cycle. The codes are 1001 for burst, 1010 for readout and 1100 for test. At all other times tx_data is low.
- R4: While auto_en is high, a tick occurs every PERIOD cycles after enable. A tick launches the combined action only when the block is idle, nothing is pending and req_valid is low. Otherwise the tick is lost. Dropping auto_en clears the timer.
- R5: A request that arrives while a mode is running is held in a one-entry slot. The held request is launched from the first idle cycle. A request that arrives while the slot is full is discarded.
- R6: The mode output reads 0 in idle, 1 in burst, 2 in readout and 3 in test.
- R7: cyc_pos is 0 in the first cycle of a mode and rises by one each cycle. It reads 0 in idle.
- R8: aux_pulse[i] is high exactly when the mode is burst and lo_i <= cyc_pos < hi_i. Here lo_i is aux_start[i*CW +: CW] and hi_i is aux_stop[i*CW +: CW]. If lo_i >= hi_i, the output never pulses. Bit 0 is clear, bit 1 is clear-gate and bit 2 is inner-substrate.
- R9: After reset the mode is idle, tx_data is low, cyc_pos is 0, all aux outputs are low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Software command request strobe |
| req_kind | input | 2 | 0 burst, 1 readout, 2 test, 3 burst then readout |
| auto_en | input | 1 | Enable periodic combined action |
| aux_start | input | NAUX*CW | Per-output window start positions |
| aux_stop | input | NAUX*CW | Per-output window end positions (exclusive) |
| tx_data | output | 1 | Serial command telegram line |
| mode | output | 2 | Current chip operating mode |
| cyc_pos | output | CW | Position within the current mode |
| aux_pulse | output | NAUX | Auxiliary pulse outputs |

## Verification
The assertions check the following on every cycle:
- tx_data stays low in idle.
- A burst that belongs to a combined action hands over to readout on the next cycle.
- The position counter steps by one inside a mode.
- Auxiliary pulses appear only during a burst.
- A held request or an accepted tick always starts a mode.
- The timer never ticks on two cycles in a row.

The bench's scenarios show the rest by comparing every output against a behavioural model on every clock. This covers the exact telegram bit patterns, the mode lengths, the window edges including an empty window, the discarding of a second request while one is held, and a tick being lost when it meets a request or a busy sequencer.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        FC_IDLE    = 2'd0,
        FC_BURST   = 2'd1,
        FC_READOUT = 2'd2,
        FC_TEST    = 2'd3
    } fc_mode_e;

    localparam int CODE_W = 4;
    localparam int TELE_W = CODE_W + 1;

    localparam logic [1:0] KIND_BURST = 2'd0;
    localparam logic [1:0] KIND_READ  = 2'd1;
    localparam logic [1:0] KIND_TEST  = 2'd2;
    localparam logic [1:0] KIND_COMBO = 2'd3;

    function automatic logic [CODE_W-1:0] cmd_code(fc_mode_e m);
        case (m)
            FC_BURST:   return 4'b1001;
            FC_READOUT: return 4'b1010;
            FC_TEST:    return 4'b1100;
            default:    return 4'b0000;
        endcase
    endfunction

    function automatic fc_mode_e kind_to_mode(logic [1:0] k);
        case (k)
            KIND_READ: return FC_READOUT;
            KIND_TEST: return FC_TEST;
            default:   return FC_BURST;
        endcase
    endfunction

endpackage

// File: rtl/fc_auto_timer.sv
module fc_auto_timer #(
    parameter int PERIOD = 10_000_000,
    localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en)       cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PERIOD > 1 && tick) |=> !tick);

endmodule

// File: rtl/fc_telegram_tx.sv
module fc_telegram_tx
    import fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic              txd
);
    logic [TELE_W-1:0] sh_d, sh_q;

    always_comb begin
        if (load) sh_d = {1'b1, code};
        else      sh_d = {sh_q[TELE_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign txd = sh_q[TELE_W-1];

    // R3
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> txd);

endmodule

// File: rtl/fc_aux_window.sv
module fc_aux_window #(
    parameter int CW = 6
) (
    input  logic          active,
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] hi,
    output logic          pulse
);
    always_comb begin
        pulse = active && (pos >= lo) && (pos < hi);
    end
endmodule

// File: rtl/fc_sequencer.sv
module fc_sequencer
    import fc_pkg::*;
#(
    parameter int BURST_CYC = 64,
    parameter int READ_CYC  = 48,
    parameter int TEST_CYC  = 16,
    parameter int NAUX      = 3,
    parameter int PERIOD    = 10_000_000,
    localparam int MAXL = (BURST_CYC > READ_CYC)
                          ? ((BURST_CYC > TEST_CYC) ? BURST_CYC : TEST_CYC)
                          : ((READ_CYC > TEST_CYC) ? READ_CYC : TEST_CYC),
    localparam int CW = (MAXL > 1) ? $clog2(MAXL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              auto_en,
    input  logic [NAUX*CW-1:0] aux_start,
    input  logic [NAUX*CW-1:0] aux_stop,
    output logic              tx_data,
    output logic [1:0]        mode,
    output logic [CW-1:0]     cyc_pos,
    output logic [NAUX-1:0]   aux_pulse
);
    localparam logic [CW-1:0] BURST_LAST = CW'(BURST_CYC - 1);
    localparam logic [CW-1:0] READ_LAST  = CW'(READ_CYC - 1);
    localparam logic [CW-1:0] TEST_LAST  = CW'(TEST_CYC - 1);

    typedef struct packed {
        fc_mode_e      mode;
        logic [CW-1:0] pos;
        logic          combo;
        logic          pend_v;
        logic [1:0]    pend_k;
    } seq_st_t;

    seq_st_t s_d, s_q;

    logic              tick;
    logic              go;
    logic [1:0]        go_kind;
    logic              tx_load;
    logic [CODE_W-1:0] tx_code;
    logic [CW-1:0]     last_pos;

    fc_auto_timer #(.PERIOD(PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (auto_en),
        .tick  (tick)
    );

    always_comb begin
        case (s_q.mode)
            FC_BURST:   last_pos = BURST_LAST;
            FC_READOUT: last_pos = READ_LAST;
            FC_TEST:    last_pos = TEST_LAST;
            default:    last_pos = '0;
        endcase
    end

    always_comb begin
        s_d     = s_q;
        go      = 1'b0;
        go_kind = KIND_BURST;
        tx_load = 1'b0;

        if (s_q.mode == FC_IDLE) begin
            if (s_q.pend_v) begin
                go       = 1'b1;
                go_kind  = s_q.pend_k;
                s_d.pend_v = req_valid;
                s_d.pend_k = req_valid ? req_kind : s_q.pend_k;
            end else if (req_valid) begin
                go      = 1'b1;
                go_kind = req_kind;
            end else if (tick) begin
                go      = 1'b1;
                go_kind = KIND_COMBO;
            end
        end else begin
            if (req_valid && !s_q.pend_v) begin
                s_d.pend_v = 1'b1;
                s_d.pend_k = req_kind;
            end
            if (s_q.pos == last_pos) begin
                s_d.pos   = '0;
                s_d.combo = 1'b0;
                if (s_q.mode == FC_BURST && s_q.combo) begin
                    s_d.mode = FC_READOUT;
                    tx_load  = 1'b1;
                end else begin
                    s_d.mode = FC_IDLE;
                end
            end else begin
                s_d.pos = s_q.pos + CW'(1);
            end
        end

        if (go) begin
            s_d.mode  = kind_to_mode(go_kind);
            s_d.combo = (go_kind == KIND_COMBO);
            s_d.pos   = '0;
            tx_load   = 1'b1;
        end

        tx_code = cmd_code(s_d.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode   <= FC_IDLE;
            s_q.pos    <= '0;
            s_q.combo  <= 1'b0;
            s_q.pend_v <= 1'b0;
            s_q.pend_k <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    fc_telegram_tx u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tx_load),
        .code  (tx_code),
        .txd   (tx_data)
    );

    logic in_burst;
    assign in_burst = (s_q.mode == FC_BURST);

    for (genvar i = 0; i < NAUX; i++) begin : g_aux
        fc_aux_window #(.CW(CW)) u_win (
            .active (in_burst),
            .pos    (s_q.pos),
            .lo     (aux_start[i*CW +: CW]),
            .hi     (aux_stop[i*CW +: CW]),
            .pulse  (aux_pulse[i])
        );
    end

    assign mode    = s_q.mode;
    assign cyc_pos = s_q.pos;

    // R3
    tx_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == FC_IDLE) |-> !tx_data);

    // R2
    combo_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == FC_BURST && s_q.combo && s_q.pos == BURST_LAST)
        |=> (s_q.mode == FC_READOUT && s_q.pos == '0));

    // R7
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode != FC_IDLE && s_q.pos != last_pos)
        |=> (s_q.pos == $past(s_q.pos) + CW'(1)));

    // R8
    aux_burst_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_pulse != '0) |-> (s_q.mode == FC_BURST));

    // R5
    pending_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == FC_IDLE && s_q.pend_v) |=> (s_q.mode != FC_IDLE));

    // R4
    tick_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.mode == FC_IDLE && !s_q.pend_v && !req_valid)
        |=> (s_q.mode == FC_BURST && s_q.combo));

endmodule

// File: tb/sim_fc_sequencer.sv
module sim_fc_sequencer;
    localparam int BL = 24, RL = 16, TL = 10, NA = 3, PER = 300;
    localparam int CW = $clog2(BL);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic auto_en = 1'b0;
    logic [NA*CW-1:0] aux_start = '0;
    logic [NA*CW-1:0] aux_stop = '0;
    logic tx_data;
    logic [1:0] mode;
    logic [CW-1:0] cyc_pos;
    logic [NA-1:0] aux_pulse;

    always #4 clk = ~clk;

    fc_sequencer #(.BURST_CYC(BL), .READ_CYC(RL), .TEST_CYC(TL),
                   .NAUX(NA), .PERIOD(PER)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .auto_en(auto_en), .aux_start(aux_start), .aux_stop(aux_stop),
        .tx_data(tx_data), .mode(mode), .cyc_pos(cyc_pos), .aux_pulse(aux_pulse)
    );

    int n_vec = 0, n_bad = 0, cycles = 0;
    string tag = "R1";

    // behavioural reference
    int m_mode = 0, m_pos = 0, m_combo = 0, m_pv = 0, m_pk = 0, m_tmr = 0;
    int q_pend[$];

    function automatic int len_of(int md);
        return (md == 1) ? BL : (md == 2) ? RL : TL;
    endfunction
    function automatic int code_of(int md);
        return (md == 1) ? 9 : (md == 2) ? 10 : 12;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_pos = 0; m_combo = 0; m_pv = 0; m_tmr = 0;
            q_pend.delete();
        end else begin
            int tick, kind, launch;
            tick = (auto_en && m_tmr == PER - 1);
            m_tmr = !auto_en ? 0 : (tick ? 0 : m_tmr + 1);
            launch = 0; kind = 0;
            if (m_mode == 0) begin
                if (q_pend.size() > 0) begin
                    kind = q_pend.pop_front(); launch = 1;
                    if (req_valid) q_pend.push_back(int'(req_kind));
                end else if (req_valid) begin
                    kind = int'(req_kind); launch = 1;
                end else if (tick) begin
                    kind = 3; launch = 1;
                end
            end else begin
                if (req_valid && q_pend.size() == 0) q_pend.push_back(int'(req_kind));
                if (m_pos == len_of(m_mode) - 1) begin
                    if (m_mode == 1 && m_combo) m_mode = 2; else m_mode = 0;
                    m_pos = 0; m_combo = 0;
                end else m_pos++;
            end
            if (launch) begin
                m_mode = (kind == 3) ? 1 : kind + 1;
                m_combo = (kind == 3);
                m_pos = 0;
            end
        end
    end

    task automatic chk(string rq, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", rq, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            int etx, eaux;
            etx = 0;
            if (m_mode != 0 && m_pos == 0) etx = 1;
            else if (m_mode != 0 && m_pos <= 4) etx = (code_of(m_mode) >> (4 - m_pos)) & 1;
            eaux = 0;
            for (int i = 0; i < NA; i++)
                if (m_mode == 1 && m_pos >= int'(aux_start[i*CW +: CW])
                    && m_pos < int'(aux_stop[i*CW +: CW])) eaux |= (1 << i);
            chk({tag, "/R6 mode"}, int'(mode), m_mode);
            chk("R3 tx", int'(tx_data), etx);
            chk("R7 pos", int'(cyc_pos), m_pos);
            chk("R8 aux", int'(aux_pulse), eaux);
        end
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic request(int k);
        req_valid = 1'b1; req_kind = 2'(k);
        step(1);
        req_valid = 1'b0;
    endtask

    task automatic set_win(int i, int lo, int hi);
        aux_start[i*CW +: CW] = CW'(lo);
        aux_stop[i*CW +: CW]  = CW'(hi);
    endtask

    initial begin
        set_win(0, 2, 6); set_win(1, 5, 20); set_win(2, 10, 10);
        step(3);
        // R9 reset state
        chk("R9 mode", int'(mode), 0);
        chk("R9 tx", int'(tx_data), 0);
        chk("R9 pos", int'(cyc_pos), 0);
        chk("R9 aux", int'(aux_pulse), 0);
        rst_n = 1'b1;
        step(2);
        tag = "R1";
        request(0); step(BL + 4);
        request(1); step(RL + 4);
        request(2); step(TL + 4);
        tag = "R2";
        request(3); step(BL + RL + 4);
        tag = "R5";
        request(3); step(3);
        request(2); step(2);
        request(1);                 // discarded: slot full
        step(BL + RL + TL + 8);
        request(0); step(BL - 1);
        request(1); step(RL + BL);
        tag = "R8";
        set_win(0, 0, 24); set_win(1, 23, 24); set_win(2, 7, 3);
        request(0); step(BL + 3);
        tag = "R4";
        auto_en = 1'b1;
        step(PER * 3 + 5);
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 37) == 0) begin
                req_valid = 1'b1; req_kind = 2'($urandom % 4);
            end else req_valid = 1'b0;
            step(1);
        end
        req_valid = 1'b0;
        auto_en = 1'b0; step(50);
        auto_en = 1'b1; step(PER + 60);
        auto_en = 1'b0; step(BL + RL + 10);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule